// File: doc/BRIEF.md
# Two-Order Burst Address Sequencer

This block produces the low-order address bits for a short burst transfer. A base value taken from the address bus is captured on a load cycle. Every later advance cycle steps the sequencer to the next beat of the burst. The upper address bits do not pass through this block. The sequencer also reports which beat of the burst is current.

Two beat orders are supported. In the linear order the address counts upward from the base and wraps modulo the burst length. In the interleaved order the address is the base XOR-ed with the beat number. A level on a mode pin picks the order, and that pin is expected to stay fixed in normal use.

One active-low strobe controls both operations: low means load, high means advance. A clock-enable input freezes the whole state. Bursting is optional. A bus master that issues a fresh address on every cycle simply keeps the strobe low, and the output then follows each new base one cycle later.

Top module: `burst_seq_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, after that edge `burst_addr` and `beat_idx` are both 0.
- R2: With `clk_en` high and `ld_n` low at a rising edge, after that edge `burst_addr` equals the `base_lo` value sampled at that edge and `beat_idx` is 0.
- R3: With `order_sel` low (linear), `burst_addr` equals (base + `beat_idx`) modulo 4.
- R4: With `order_sel` high (interleaved), `burst_addr` equals base XOR `beat_idx`.
- R5: Each rising edge with `clk_en` high and `ld_n` high raises `beat_idx` by one modulo 4. After the fourth beat the sequence returns to the base and keeps cycling without a reload.
- R6: A rising edge with `clk_en` low leaves `burst_addr` and `beat_idx` unchanged. This holds whatever the values of `ld_n` and `base_lo`.
- R7: When `ld_n` is low on consecutive enabled edges, each edge loads its own base, and `beat_idx` stays at 0.
- R8: A load in the middle of a burst restarts the sequence at the new base, with `beat_idx` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | High: state may change; low: state held |
| ld_n | input | 1 | Low: load base; high: advance one beat |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| base_lo | input | BURST_BITS (2) | Low address bits captured on a load |
| burst_addr | output | BURST_BITS (2) | Current low address bits of the burst |
| beat_idx | output | BURST_BITS (2) | Number of the current beat, 0 to 3 |

## Verification
The hardest situation to reach from the ports is a suspended cycle that falls inside a burst while the strobe is low and the base bus carries a different value. If the clock enable were not gating the load, that cycle would silently restart the burst. The stimulus first runs partway into a burst. It then drops the clock enable while driving a load with a new base, and after that lets the burst continue through its wrap point. This is done for every base value in both orders. The expected address is compared on every clock.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the burst address sequencer.
// Assumes the mode pin encodes the order as a single bit.
package burst_pkg;
    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
`timescale 1ns/1ps
// Holds the captured base and the running beat number.
// Load has priority over advance; clk_en low freezes both registers.
// Assumes a synchronous active-low reset.
module burst_beat_ctr #(
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_en,
    input  logic                  ld_n,
    input  logic [BURST_BITS-1:0] base_lo,
    output logic [BURST_BITS-1:0] base_q,
    output logic [BURST_BITS-1:0] beat_q
);
    localparam logic [BURST_BITS-1:0] BEAT_ONE = BURST_BITS'(1);

    // Capture the base on a load, step the beat on an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (clk_en) begin
            if (!ld_n) begin
                base_q <= base_lo;
                beat_q <= '0;
            end else begin
                beat_q <= beat_q + BEAT_ONE;
            end
        end
    end
endmodule

// File: rtl/burst_order_map.sv
`timescale 1ns/1ps
// Maps base and beat number to the burst address for the chosen order.
// Purely combinational; the wrap comes from the modulo-2^BURST_BITS width.
module burst_order_map #(
    parameter int BURST_BITS = 2
) (
    input  burst_pkg::burst_order_e order,
    input  logic [BURST_BITS-1:0]   base_q,
    input  logic [BURST_BITS-1:0]   beat_q,
    output logic [BURST_BITS-1:0]   addr
);
    logic [BURST_BITS-1:0] lin_addr;
    logic [BURST_BITS-1:0] ilv_addr;

    // Linear order uses a wrapping sum; interleaved order flips the bits of the base, one beat bit each.
    assign lin_addr = base_q + beat_q;
    for (genvar b = 0; b < BURST_BITS; b++) begin : g_ilv
        assign ilv_addr[b] = base_q[b] ^ beat_q[b];
    end

    // Pick the sequence that the mode pin asks for.
    always_comb begin
        addr = (order == burst_pkg::ORDER_INTERLEAVED) ? ilv_addr : lin_addr;
    end
endmodule

// File: rtl/burst_seq_gen.sv
`timescale 1ns/1ps
// Top of the burst address sequencer: a state register pair and an order map.
// Assumes order_sel is static once a burst starts; outputs follow the registers.
module burst_seq_gen #(
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_en,
    input  logic                  ld_n,
    input  logic                  order_sel,
    input  logic [BURST_BITS-1:0] base_lo,
    output logic [BURST_BITS-1:0] burst_addr,
    output logic [BURST_BITS-1:0] beat_idx
);
    logic [BURST_BITS-1:0]  base_q;
    logic [BURST_BITS-1:0]  beat_q;
    burst_pkg::burst_order_e order;

    // Convert the raw mode pin into the order type.
    always_comb order = burst_pkg::burst_order_e'(order_sel);

    burst_beat_ctr #(.BURST_BITS(BURST_BITS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .ld_n    (ld_n),
        .base_lo (base_lo),
        .base_q  (base_q),
        .beat_q  (beat_q)
    );

    burst_order_map #(.BURST_BITS(BURST_BITS)) u_map (
        .order  (order),
        .base_q (base_q),
        .beat_q (beat_q),
        .addr   (burst_addr)
    );

    assign beat_idx = beat_q;
endmodule

// File: rtl/burst_seq_gen_chk.sv
`timescale 1ns/1ps
// Temporal checks on the sequencer ports, bound to every instance of the top module.
module burst_seq_gen_chk #(
    parameter int BURST_BITS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clk_en,
    input logic                  ld_n,
    input logic                  order_sel,
    input logic [BURST_BITS-1:0] base_lo,
    input logic [BURST_BITS-1:0] burst_addr,
    input logic [BURST_BITS-1:0] beat_idx
);
    localparam logic [BURST_BITS-1:0] ONE = BURST_BITS'(1);

    // R1: reset clears both outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (burst_addr == '0 && beat_idx == '0));

    // R2: a load shows its base at beat 0 on the next cycle
    p_load_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !ld_n) |=> (beat_idx == '0 && burst_addr == $past(base_lo)));

    // R3: in linear order each advance adds one to the address
    p_linear_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && ld_n && !order_sel) |=>
            (!order_sel -> burst_addr == BURST_BITS'($past(burst_addr) + ONE)));

    // R4: in interleaved order address XOR beat stays equal to the base
    p_ilv_invariant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && ld_n && order_sel) |=>
            (order_sel -> (burst_addr ^ beat_idx) == $past(burst_addr ^ beat_idx)));

    // R5: an advance raises the beat number by one, wrapping
    p_beat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && ld_n) |=> beat_idx == BURST_BITS'($past(beat_idx) + ONE));

    // R6: a suspended cycle changes nothing
    p_suspend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(beat_idx) && ($stable(order_sel) -> $stable(burst_addr))));
endmodule

bind burst_seq_gen burst_seq_gen_chk #(.BURST_BITS(BURST_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .ld_n       (ld_n),
    .order_sel  (order_sel),
    .base_lo    (base_lo),
    .burst_addr (burst_addr),
    .beat_idx   (beat_idx)
);

// File: tb/test_burst_seq_gen.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the outputs on every clock.
module test_burst_seq_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       ld_n = 1'b1;
    logic       order_sel = 1'b0;
    logic [1:0] base_lo = 2'd0;
    logic [1:0] burst_addr;
    logic [1:0] beat_idx;

    int n_tests = 0;
    int n_fail  = 0;
    int m_base  = 0;
    int m_beat  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    burst_seq_gen i_burst_seq_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .ld_n       (ld_n),
        .order_sel  (order_sel),
        .base_lo    (base_lo),
        .burst_addr (burst_addr),
        .beat_idx   (beat_idx)
    );

    // One clock: drive inputs, update the model at the edge, compare at the falling edge.
    task automatic cyc(input bit rst, input bit en, input bit ld, input bit mode,
                       input int base, input string tag);
        int exp_addr;
        rst_n = rst; clk_en = en; ld_n = ld; order_sel = mode; base_lo = 2'(base);
        @(posedge clk);
        if (!rst) begin
            m_base = 0; m_beat = 0;
        end else if (en) begin
            if (!ld) begin m_base = base; m_beat = 0; end
            else m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        exp_addr = mode ? (m_base ^ m_beat) : ((m_base + m_beat) % 4);
        n_tests++;
        if (int'(burst_addr) != exp_addr || int'(beat_idx) != m_beat) begin
            n_fail++;
            $display("FAIL %s: addr=%0d beat=%0d expected addr=%0d beat=%0d",
                     tag, burst_addr, beat_idx, exp_addr, m_beat);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cyc(0, 1, 0, 0, 3, "R1");
        cyc(0, 1, 1, 1, 2, "R1");
        // R2 load, R3/R4 order, R5 wrap: every base in both orders, two passes round
        for (int mode = 0; mode < 2; mode++) begin
            for (int b = 0; b < 4; b++) begin
                cyc(1, 1, 0, mode[0], b, "R2");
                for (int k = 0; k < 7; k++)
                    cyc(1, 1, 1, mode[0], (b + 1) % 4, mode ? "R4/R5" : "R3/R5");
            end
        end
        // R6: suspend mid-burst with a conflicting load on the bus
        for (int mode = 0; mode < 2; mode++) begin
            for (int b = 0; b < 4; b++) begin
                cyc(1, 1, 0, mode[0], b, "R2");
                cyc(1, 1, 1, mode[0], 0, "R5");
                cyc(1, 0, 0, mode[0], (b + 2) % 4, "R6");
                cyc(1, 0, 1, mode[0], (b + 3) % 4, "R6");
                cyc(1, 0, 0, mode[0], (b + 1) % 4, "R6");
                for (int k = 0; k < 4; k++)
                    cyc(1, 1, 1, mode[0], 0, "R6/R5");
            end
        end
        // R7: a fresh load on every cycle
        for (int k = 0; k < 12; k++)
            cyc(1, 1, 0, k[2], (k * 3 + 1) % 4, "R7");
        // R8: reload in mid-burst restarts at the new base
        for (int mode = 0; mode < 2; mode++) begin
            cyc(1, 1, 0, mode[0], 1, "R2");
            cyc(1, 1, 1, mode[0], 0, "R5");
            cyc(1, 1, 1, mode[0], 0, "R5");
            cyc(1, 1, 0, mode[0], 2, "R8");
            cyc(1, 1, 1, mode[0], 0, "R8");
            cyc(1, 1, 1, mode[0], 0, "R8");
        end
        // R1: reset in mid-burst
        cyc(1, 1, 0, 1, 3, "R2");
        cyc(1, 1, 1, 1, 3, "R5");
        cyc(0, 1, 1, 1, 3, "R1");
        cyc(1, 1, 1, 0, 0, "R5");
        done = 1'b1;
    end

    // Ends the run: normal completion or an expired watchdog.
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual=expired expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule